// File: doc/BRIEF.md
# Subset Microcontroller Execute Core

This block is the execute stage of a small 8-bit controller whose program words are 13 bits wide. Each clock it presents a program address, takes the instruction word that an external program store returns in the same cycle, and retires that instruction before the next edge. The implemented instructions are: no-op, the two interrupt-enable controls, plain return and return-from-interrupt, a computed jump that adds the accumulator to the low byte of the program counter, register move, clearing of the accumulator or a register, and two subtract forms. Every other word runs as a no-op.

Operands come from a 64-address register space. Three addresses are special: the program-counter low byte, the flag register and the bank selector. The upper half of the space is banked by the two top bits of the bank selector. An 8-entry hardware return stack holds return addresses. A level-sensitive interrupt request, when enabled, pre-empts the fetched instruction and vectors the core to address 0x008.

The accumulator, the flags, the program counter and the global interrupt enable are visible as outputs. Register contents can be read through the normal instruction path: clear the accumulator, then subtract it from the register.

Top module: `uc_exec_core`

## Requirements
- R1: While reset is asserted, and through the two cycles the reset synchronizer needs after release, the program address is 0, the accumulator is 0, all flags are 0 and the interrupt enable is 0.
- R2: Word 0x0000 and every word outside the implemented subset advances the program address by one (modulo 2^11) and changes no other state.
- R3: Word 0x0080 (clear accumulator) and group 7'b0000011 in bits 12:6 (clear register, address in bits 5:0) write zero to the destination and set Z, leaving C and DC unchanged. Group 7'b0000001 (move) copies the accumulator to the addressed register and changes no flag, unless that register is the flag register.
- R4: Groups 7'b0000100 and 7'b0000101 compute register minus accumulator. The first form writes the result to the accumulator and the second to the register. Z is set for a zero result, C when the register is not below the accumulator, and DC when the register's low nibble is not below the accumulator's low nibble.
- R5: Addresses 0x20 to 0x3F reach one of four banks chosen by bits 7:6 of address 0x04. Addresses 0x00, 0x01 and 0x05 to 0x1F are shared by all banks. Address 0x04 reads back what was written to it.
- R6: Address 0x02 reads as the low byte of the next sequential address. Writing it jumps to that value, with the upper three bits taken from the next sequential address. Word 0x0020 adds the accumulator to that low byte in the same way, and the carry out of the low byte is dropped.
- R7: Address 0x03 holds C in bit 0, DC in bit 1 and Z in bit 2, and its other bits read as 0. When an instruction both writes this address and updates flags, the flag update wins.
- R8: Word 0x0010 sets the interrupt enable and 0x0011 clears it. Word 0x0012 loads the program address from the return stack. Word 0x0013 does the same and also sets the interrupt enable.
- R9: With the request high and interrupts enabled, the fetched word is not executed. The core pushes that word's address, jumps to 0x008 and clears the enable. With interrupts disabled, the request has no effect.
- R10: The return stack holds 8 entries. A push onto a full stack drops the oldest entry. A pop from an empty stack returns the bottom entry (the one popped last) and leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Level interrupt request |
| instr_i | input | 13 | Instruction word at pc_o |
| pc_o | output | 11 | Program address being executed |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 3 | Flags {Z, DC, C} |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The bound checker watches, on every cycle, the per-instruction effects that can be seen at the ports: the jump to the vector and the loss of the enable when an interrupt is taken, the program-address step and the held state around a no-op, the enable changes, the accumulator and Z after a clear or subtract, and the return-stack depth bound. Bank isolation, the read-back of registers through subtraction, the arithmetic of the computed jump, the priority of flag updates over writes to the flag register, and the order of the return stack across an overflow and an empty pop depend on history. Only the bench's directed and random scenarios, checked against its reference model, can show those.

// File: rtl/uc_pkg.sv
package uc_pkg;
  localparam int INSTR_W    = 13;
  localparam int REG_AW     = 6;
  localparam int FLAG_W     = 3;
  localparam int IRQ_VECTOR = 8;

  localparam logic [REG_AW-1:0] A_PCL  = 6'd2;
  localparam logic [REG_AW-1:0] A_STAT = 6'd3;
  localparam logic [REG_AW-1:0] A_BANK = 6'd4;

  typedef enum logic [3:0] {
    OP_NOP, OP_ENI, OP_DISI, OP_RET, OP_RETI, OP_TBL,
    OP_CLRA, OP_MOVRA, OP_CLRR, OP_SUBA, OP_SUBR
  } op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/uc_decode.sv
module uc_decode
  import uc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic [REG_AW-1:0]  raddr_o
);
  localparam int GRP_W = INSTR_W - REG_AW;

  logic [GRP_W-1:0] grp;

  assign grp     = instr_i[INSTR_W-1:REG_AW];
  assign raddr_o = instr_i[REG_AW-1:0];

  always_comb begin
    case (instr_i)
      13'h0010: op_o = OP_ENI;
      13'h0011: op_o = OP_DISI;
      13'h0012: op_o = OP_RET;
      13'h0013: op_o = OP_RETI;
      13'h0020: op_o = OP_TBL;
      13'h0080: op_o = OP_CLRA;
      default: begin
        case (grp)
          7'h01:   op_o = OP_MOVRA;
          7'h03:   op_o = OP_CLRR;
          7'h04:   op_o = OP_SUBA;
          7'h05:   op_o = OP_SUBR;
          default: op_o = OP_NOP;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] reg_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] diff_o,
  output flags_t            flags_o,
  output logic              upd_o
);
  localparam int NIB = 4;

  logic [DATA_W:0] wide;
  logic [NIB:0]    low;

  assign wide   = {1'b0, reg_i} - {1'b0, acc_i};
  assign low    = {1'b0, reg_i[NIB-1:0]} - {1'b0, acc_i[NIB-1:0]};
  assign diff_o = wide[DATA_W-1:0];

  always_comb begin
    flags_o = flags_i;
    upd_o   = 1'b0;
    case (op_i)
      OP_SUBA, OP_SUBR: begin
        upd_o      = 1'b1;
        flags_o.z  = (wide[DATA_W-1:0] == '0);
        flags_o.c  = ~wide[DATA_W];
        flags_o.dc = ~low[NIB];
      end
      OP_CLRA, OP_CLRR: begin
        upd_o     = 1'b1;
        flags_o.z = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uc_regfile.sv
module uc_regfile #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 6,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_W      = 2,
  parameter int BANKED_BASE = 32
) (
  input  logic              clk,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int WIN   = (1 << ADDR_W) - BANKED_BASE;
  localparam int OFF_W = $clog2(WIN);
  localparam int COM_W = $clog2(BANKED_BASE);

  logic [DATA_W-1:0] com_q   [BANKED_BASE];
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];
  logic              hi_rd, hi_wr;
  logic [ADDR_W-1:0] rd_rel, wr_rel;
  logic [OFF_W-1:0]  rd_off, wr_off;

  assign hi_rd  = rd_addr_i >= ADDR_W'(BANKED_BASE);
  assign hi_wr  = wr_addr_i >= ADDR_W'(BANKED_BASE);
  assign rd_rel = rd_addr_i - ADDR_W'(BANKED_BASE);
  assign wr_rel = wr_addr_i - ADDR_W'(BANKED_BASE);
  assign rd_off = rd_rel[OFF_W-1:0];
  assign wr_off = wr_rel[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (we_i && !hi_wr) com_q[wr_addr_i[COM_W-1:0]] <= wr_data_i;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [WIN];
    always_ff @(posedge clk) begin
      if (we_i && hi_wr && (bank_i == BANK_W'(b))) mem_q[wr_off] <= wr_data_i;
    end
    assign bank_rd[b] = mem_q[rd_off];
  end

  assign rd_data_o = hi_rd ? bank_rd[bank_i] : com_q[rd_addr_i[COM_W-1:0]];
endmodule

// File: rtl/uc_rstack.sv
module uc_rstack #(
  parameter int W     = 11,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     push_val_i,
  input  logic             pop_i,
  output logic [W-1:0]     top_o,
  output logic [CNT_W-1:0] depth_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_dn;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             empty, full;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign ptr_dn = ptr_q - PTR_W'(1);
  assign top_o  = empty ? mem_q[ptr_q] : mem_q[ptr_dn];

  always_comb begin
    ptr_n = ptr_q;
    cnt_n = cnt_q;
    if (push_i) begin
      ptr_n = ptr_q + PTR_W'(1);
      if (!full) cnt_n = cnt_q + CNT_W'(1);
    end else if (pop_i && !empty) begin
      ptr_n = ptr_dn;
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i || pop_i) begin
      ptr_q <= ptr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[ptr_q] <= push_val_i;
  end

  assign depth_o = cnt_q;
endmodule

// File: rtl/uc_exec_core.sv
module uc_exec_core
  import uc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PC_W        = 11,
  parameter int STACK_DEPTH = 8,
  parameter int NUM_BANKS   = 4,
  parameter int BANKED_BASE = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [DATA_W-1:0]  acc_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               gie_o
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = $clog2(STACK_DEPTH + 1);
  localparam int HI_W   = PC_W - DATA_W;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // architectural state
  logic [PC_W-1:0]   pc_q, pc_n;
  logic [DATA_W-1:0] acc_q, acc_n;
  flags_t            flags_q, flags_n;
  logic              gie_q, gie_n;
  logic [DATA_W-1:0] bank_q, bank_n;
  logic              acc_en, flags_en, gie_en, bank_en;

  // datapath
  op_e               op_dec, op;
  logic [REG_AW-1:0] raddr;
  logic              take_irq;
  logic [PC_W-1:0]   pc_inc;
  logic [DATA_W-1:0] rf_rd, rd_val, alu_diff, wr_val, tbl_low;
  flags_t            alu_flags;
  logic              alu_upd, wr_en, rf_we, stat_wr;
  logic              st_push, st_pop;
  logic [PC_W-1:0]   st_top;
  logic [CNT_W-1:0]  st_depth;

  uc_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op_dec),
    .raddr_o (raddr)
  );

  assign take_irq = irq_i && gie_q;
  assign op       = take_irq ? OP_NOP : op_dec;
  assign pc_inc   = pc_q + PC_W'(1);

  uc_regfile #(
    .DATA_W      (DATA_W),
    .ADDR_W      (REG_AW),
    .NUM_BANKS   (NUM_BANKS),
    .BANK_W      (BANK_W),
    .BANKED_BASE (BANKED_BASE)
  ) u_rf (
    .clk       (clk),
    .bank_i    (bank_q[DATA_W-1 -: BANK_W]),
    .rd_addr_i (raddr),
    .rd_data_o (rf_rd),
    .we_i      (rf_we),
    .wr_addr_i (raddr),
    .wr_data_i (wr_val)
  );

  always_comb begin
    case (raddr)
      A_PCL:   rd_val = pc_inc[DATA_W-1:0];
      A_STAT:  rd_val = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
      A_BANK:  rd_val = bank_q;
      default: rd_val = rf_rd;
    endcase
  end

  uc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (op),
    .acc_i   (acc_q),
    .reg_i   (rd_val),
    .flags_i (flags_q),
    .diff_o  (alu_diff),
    .flags_o (alu_flags),
    .upd_o   (alu_upd)
  );

  assign wr_en   = (op == OP_MOVRA) || (op == OP_CLRR) || (op == OP_SUBR);
  assign wr_val  = (op == OP_MOVRA) ? acc_q : ((op == OP_CLRR) ? '0 : alu_diff);
  assign rf_we   = wr_en && (raddr != A_PCL) && (raddr != A_STAT) && (raddr != A_BANK);
  assign stat_wr = wr_en && (raddr == A_STAT);
  assign tbl_low = pc_inc[DATA_W-1:0] + acc_q;

  assign st_push = take_irq;
  assign st_pop  = (op == OP_RET) || (op == OP_RETI);

  uc_rstack #(.W(PC_W), .DEPTH(STACK_DEPTH), .CNT_W(CNT_W)) u_stack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .push_i     (st_push),
    .push_val_i (pc_q),
    .pop_i      (st_pop),
    .top_o      (st_top),
    .depth_o    (st_depth)
  );

  // next-state logic
  always_comb begin
    pc_n = pc_inc;
    if (take_irq)                         pc_n = PC_W'(IRQ_VECTOR);
    else if (st_pop)                      pc_n = st_top;
    else if (op == OP_TBL)                pc_n = {pc_inc[PC_W-1 -: HI_W], tbl_low};
    else if (wr_en && (raddr == A_PCL))   pc_n = {pc_inc[PC_W-1 -: HI_W], wr_val};

    acc_en = (op == OP_CLRA) || (op == OP_SUBA);
    acc_n  = (op == OP_CLRA) ? '0 : alu_diff;

    flags_en = alu_upd || stat_wr;
    flags_n  = alu_upd ? alu_flags : flags_t'(wr_val[FLAG_W-1:0]);

    bank_en = wr_en && (raddr == A_BANK);
    bank_n  = wr_val;

    gie_en = take_irq || (op == OP_ENI) || (op == OP_DISI) || (op == OP_RETI);
    gie_n  = !take_irq && (op != OP_DISI);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      gie_q   <= 1'b0;
      bank_q  <= '0;
    end else begin
      pc_q <= pc_n;
      if (acc_en)   acc_q   <= acc_n;
      if (flags_en) flags_q <= flags_n;
      if (gie_en)   gie_q   <= gie_n;
      if (bank_en)  bank_q  <= bank_n;
    end
  end

  assign pc_o    = pc_q;
  assign acc_o   = acc_q;
  assign flags_o = flags_q;
  assign gie_o   = gie_q;
endmodule

// File: rtl/uc_exec_core_chk.sv
module uc_exec_core_chk #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 11,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_i,
  input logic [12:0]       instr_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [2:0]        flags_o,
  input logic              gie_o,
  input logic [CNT_W-1:0]  depth
);
  logic quiet;
  assign quiet = !(irq_i && gie_o);

  // R9
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i && gie_o |=> (pc_o == PC_W'(8)) && !gie_o);

  // R2
  nop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i == 13'h0000) |=>
      (pc_o == PC_W'($past(pc_o) + PC_W'(1))) && $stable(acc_o) && $stable(flags_o) && $stable(gie_o));

  // R8
  eni_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i == 13'h0010) |=> gie_o);

  // R8
  disi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i == 13'h0011) |=> !gie_o);

  // R8
  reti_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i == 13'h0013) |=> gie_o);

  // R3
  clra_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i == 13'h0080) |=> (acc_o == '0) && flags_o[2]);

  // R3
  mov_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i[12:6] == 7'h01) |=> $stable(acc_o));

  // R4
  sub_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && (instr_i[12:6] == 7'h04) |=> (flags_o[2] == (acc_o == '0)));

  // R10
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));
endmodule

bind uc_exec_core uc_exec_core_chk #(
  .DATA_W (DATA_W),
  .PC_W   (PC_W),
  .DEPTH  (STACK_DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .irq_i   (irq_i),
  .instr_i (instr_i),
  .pc_o    (pc_o),
  .acc_o   (acc_o),
  .flags_o (flags_o),
  .gie_o   (gie_o),
  .depth   (st_depth)
);

// File: tb/uc_exec_core_tb_top.sv
module uc_exec_core_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq;
  logic [12:0] instr;
  logic [10:0] pc;
  logic [7:0]  acc;
  logic [2:0]  flags;
  logic        gie;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  uc_exec_core dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq),
    .instr_i (instr),
    .pc_o    (pc),
    .acc_o   (acc),
    .flags_o (flags),
    .gie_o   (gie)
  );

  // reference model state
  logic [10:0] m_pc;
  logic [7:0]  m_acc;
  logic [2:0]  m_flags;
  logic        m_gie;
  logic [7:0]  m_bank;
  logic [7:0]  m_com [32];
  logic [7:0]  m_bnk [4][32];
  logic [10:0] m_stk [$];
  logic [10:0] m_bot;
  logic        m_bot_ok = 1'b0;

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [22:0] act, input logic [22:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h ({gie,flags,acc,pc})", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [5:0] a);
    logic [10:0] nx;
    nx = m_pc + 11'd1;
    case (a)
      6'd2:    return nx[7:0];
      6'd3:    return {5'd0, m_flags};
      6'd4:    return m_bank;
      default: return (a < 6'd32) ? m_com[a[4:0]] : m_bnk[m_bank[7:6]][a[4:0]];
    endcase
  endfunction

  function automatic logic [10:0] m_pop();
    logic [10:0] v;
    if (m_stk.size() > 0) begin
      v = m_stk.pop_back();
      if (m_stk.size() == 0) begin
        m_bot = v;
        m_bot_ok = 1'b1;
      end
    end else begin
      v = m_bot;
    end
    return v;
  endfunction

  task automatic m_exec(input logic [12:0] ins, input logic irq_v);
    logic [10:0] nx, pcn;
    logic [5:0]  a;
    logic [6:0]  g;
    logic [7:0]  r, v;
    logic [8:0]  d;
    logic [2:0]  fl;
    logic        wr, fupd;
    nx = m_pc + 11'd1; pcn = nx; a = ins[5:0]; g = ins[12:6];
    r = m_rd(a); v = 8'd0; wr = 1'b0; fupd = 1'b0; fl = m_flags;
    if (irq_v && m_gie) begin
      m_stk.push_back(m_pc);
      if (m_stk.size() > 8) void'(m_stk.pop_front());
      m_pc = 11'd8;
      m_gie = 1'b0;
      return;
    end
    if (ins == 13'h0010) m_gie = 1'b1;
    else if (ins == 13'h0011) m_gie = 1'b0;
    else if (ins == 13'h0012) pcn = m_pop();
    else if (ins == 13'h0013) begin pcn = m_pop(); m_gie = 1'b1; end
    else if (ins == 13'h0020) pcn = {nx[10:8], nx[7:0] + m_acc};
    else if (ins == 13'h0080) begin m_acc = 8'd0; fl[2] = 1'b1; fupd = 1'b1; end
    else if (g == 7'h01) begin v = m_acc; wr = 1'b1; end
    else if (g == 7'h03) begin v = 8'd0; wr = 1'b1; fl[2] = 1'b1; fupd = 1'b1; end
    else if (g == 7'h04 || g == 7'h05) begin
      d = {1'b0, r} - {1'b0, m_acc};
      v = d[7:0];
      fl = {d[7:0] == 8'd0, r[3:0] >= m_acc[3:0], r >= m_acc};
      fupd = 1'b1;
      if (g == 7'h04) m_acc = v; else wr = 1'b1;
    end
    if (wr) begin
      case (a)
        6'd2:    pcn = {nx[10:8], v};
        6'd3:    m_flags = v[2:0];
        6'd4:    m_bank = v;
        default: if (a < 6'd32) m_com[a[4:0]] = v; else m_bnk[m_bank[7:6]][a[4:0]] = v;
      endcase
    end
    if (fupd) m_flags = fl;
    m_pc = pcn;
  endtask

  function automatic string auto_tag(input logic [12:0] ins, input logic irq_v);
    logic [6:0] g;
    g = ins[12:6];
    if (irq_v) return "R9";
    if (ins >= 13'h0010 && ins <= 13'h0013) return "R8";
    if (ins == 13'h0020) return "R6";
    if (ins == 13'h0080) return "R3";
    if (g == 7'h01 || g == 7'h03 || g == 7'h04 || g == 7'h05) begin
      if (ins[5:0] == 6'd2) return "R6";
      if (ins[5:0] == 6'd3) return "R7";
      if (ins[5:0] == 6'd4 || ins[5:0] >= 6'd32) return "R5";
      return (g == 7'h04 || g == 7'h05) ? "R4" : "R3";
    end
    return "R2";
  endfunction

  task automatic step(input logic [12:0] ins, input logic irq_v, input string tag);
    string t;
    t = (tag == "") ? auto_tag(ins, irq_v) : tag;
    instr = ins;
    irq = irq_v;
    m_exec(ins, irq_v);
    @(posedge clk);
    @(negedge clk);
    check({gie, flags, acc, pc} == {m_gie, m_flags, m_acc, m_pc}, t,
          {gie, flags, acc, pc}, {m_gie, m_flags, m_acc, m_pc});
  endtask

  task automatic load_acc(input logic [7:0] v);
    step(13'h0080, 1'b0, "");
    while (8'(m_pc + 11'd1) != v) step(13'h0000, 1'b0, "R2");
    step({7'h04, 6'd2}, 1'b0, "R6");
  endtask

  function automatic logic [12:0] rnd_ins();
    logic [5:0]  a;
    logic [12:0] w;
    a = 6'($urandom_range(0, 63));
    case ($urandom_range(0, 15))
      0:       w = 13'h0000;
      1:       w = 13'h0010;
      2:       w = 13'h0011;
      3:       w = 13'h0012;
      4:       w = 13'h0013;
      5:       w = 13'h0020;
      6:       w = 13'h0080;
      7, 8:    w = {7'h01, a};
      9:       w = {7'h03, a};
      10, 11:  w = {7'h04, a};
      12, 13:  w = {7'h05, a};
      default: w = 13'($urandom);
    endcase
    if ((w == 13'h0012 || w == 13'h0013) && m_stk.size() == 0 && !m_bot_ok) w = 13'h0000;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq = 1'b0; instr = 13'h0000;
    m_pc = '0; m_acc = '0; m_flags = '0; m_gie = 1'b0; m_bank = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check({gie, flags, acc, pc} == 23'd0, "R1", {gie, flags, acc, pc}, 23'd0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    // R1: still reset values after synchronizer release
    check({gie, flags, acc, pc} == 23'd0, "R1", {gie, flags, acc, pc}, 23'd0);

    // clear the shared registers and every bank
    step(13'h0080, 1'b0, "R3");
    for (int a = 0; a < 32; a++)
      if (a < 2 || a > 4) step({7'h01, 6'(a)}, 1'b0, "R3");
    for (int b = 0; b < 4; b++) begin
      load_acc(8'(b << 6));
      step({7'h01, 6'd4}, 1'b0, "R5");
      step(13'h0080, 1'b0, "R3");
      for (int a = 32; a < 64; a++) step({7'h01, 6'(a)}, 1'b0, "R5");
    end

    // R4: nibble borrow only, equal operands, full borrow, read back
    load_acc(8'h10); step({7'h01, 6'd5}, 1'b0, "R3");
    load_acc(8'h01); step({7'h04, 6'd5}, 1'b0, "R4");
    load_acc(8'h20); step({7'h01, 6'd6}, 1'b0, "R3");
    step({7'h04, 6'd6}, 1'b0, "R4");
    load_acc(8'h05); step({7'h01, 6'd7}, 1'b0, "R3");
    load_acc(8'h06); step({7'h05, 6'd7}, 1'b0, "R4");
    step(13'h0080, 1'b0, "R3"); step({7'h04, 6'd7}, 1'b0, "R4");

    // R5: same banked address, two banks
    load_acc(8'h40); step({7'h01, 6'd4}, 1'b0, "R5");
    load_acc(8'h77); step({7'h01, 6'h25}, 1'b0, "R5");
    load_acc(8'h80); step({7'h01, 6'd4}, 1'b0, "R5");
    step(13'h0080, 1'b0, "R5"); step({7'h04, 6'h25}, 1'b0, "R5");
    load_acc(8'h40); step({7'h01, 6'd4}, 1'b0, "R5");
    step(13'h0080, 1'b0, "R5"); step({7'h04, 6'h25}, 1'b0, "R5");

    // R7: flag register writes and priority of flag update
    load_acc(8'h05); step({7'h01, 6'd3}, 1'b0, "R7");
    step({7'h03, 6'd3}, 1'b0, "R7");
    load_acc(8'hFA); step({7'h01, 6'd3}, 1'b0, "R7");
    step(13'h0080, 1'b0, "R7"); step({7'h04, 6'd3}, 1'b0, "R7");

    // R6: computed jump with low-byte wrap and a direct low-byte write
    load_acc(8'hF0); step(13'h0020, 1'b0, "R6");
    step({7'h01, 6'd2}, 1'b0, "R6");

    // R2: unlisted encodings
    step(13'h1FFF, 1'b0, "R2"); step(13'h0081, 1'b0, "R2"); step(13'h0001, 1'b0, "R2");

    // R9: request ignored while disabled
    step(13'h0011, 1'b0, "R8"); step(13'h0000, 1'b1, "R9");

    // R10: ten nested interrupts, then eleven returns
    step(13'h0010, 1'b0, "R8");
    for (int i = 0; i < 10; i++) begin
      step(13'h0000, 1'b1, "R9");
      step(13'h0010, 1'b0, "R8");
      for (int k = 0; k < i; k++) step(13'h0000, 1'b0, "R2");
    end
    for (int i = 0; i < 11; i++) step(13'h0012, 1'b0, "R10");
    step(13'h0013, 1'b0, "R10");

    // random mix
    for (int i = 0; i < 3000; i++) step(rnd_ins(), ($urandom_range(0, 15) == 0), "");

    summary();
    $finish;
  end
endmodule